// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides when a small 8-bit microcontroller core may run and which clocks stay alive. Software asks for a low-power state by writing a two-bit power-control register. The bit at position 0 requests idle and the bit at position 1 requests power-down. In idle the core clock is gated off while the peripheral, timer and interrupt clocks keep running, so any enabled interrupt can wake the core. In power-down the oscillator enable drops, every clock stops, and all state is held until reset.

When software sets both request bits in one write, power-down wins. Idle ends when any enabled interrupt line is high. Hardware then clears the idle bit, and software can read that back after it wakes. Power-down ends only through reset. Reset turns the oscillator on at once. The core clock then stays gated for a programmable number of oscillator cycles, so that the oscillator can settle before the first instruction runs.

Top module: `lpm_ctrl`

## Requirements
- R1: A write accepted in run mode with only bit 0 set makes the controller enter idle on that clock edge. After the edge, `mode` reads 2'b01 and `ctl_rdata` reads 2'b01.
- R2: A write in run mode with both bit 0 and bit 1 set enters power-down (`mode` = 2'b10), not idle. `ctl_rdata` then reads 2'b11.
- R3: In idle, if any bit of `irq_req` is high at a clock edge, the controller returns to run on that edge. `ctl_rdata` bit 0 reads 0 and `cpu_clk_en` reads 1 afterwards.
- R4: In power-down, with reset released, `osc_en`, `cpu_clk_en` and `per_clk_en` are all 0.
- R5: Power-down is not left through interrupts or register writes. `mode` stays 2'b10 until reset.
- R6: While the controller is not in run mode, register writes are ignored. In power-down, `ctl_rdata` and `mode` hold their values.
- R7: In idle, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` are 1.
- R8: Reset applied in idle or run returns the controller to run with `ctl_rdata` = 2'b00. `cpu_clk_en` is 1 as soon as reset is released.
- R9: While reset is asserted, `osc_en` is 1. If reset arrives in power-down, then after release `mode` reads 2'b00 and `cpu_clk_en` and `per_clk_en` stay 0. `cpu_clk_en` becomes 1 on the max(`stab_cycles`,1)-th clock edge after release.
- R10: `mode` encodes run as 2'b00, idle as 2'b01 and power-down as 2'b10, and never shows 2'b11. After the first reset the controller is in run.
- R11: A run-mode write with both bits 0 keeps the controller in run and reads back 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Power-control register write strobe |
| wr_data | input | 2 | Write data: bit 0 idle request, bit 1 power-down request |
| irq_req | input | N_IRQ | Enabled interrupt requests, one per line |
| stab_cycles | input | CNT_W | Oscillator settle count applied after reset from power-down |
| ctl_rdata | output | 2 | Readback of the idle (bit 0) and power-down (bit 1) bits |
| mode | output | 2 | Current mode: 00 run, 01 idle, 10 power-down |
| cpu_clk_en | output | 1 | Core clock gate enable |
| per_clk_en | output | 1 | Peripheral, timer and interrupt clock gate enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
The bench builds the block with N_IRQ=4 and CNT_W=4. With four interrupt lines, a wake from each single line and from several lines at once can be produced cheaply. With a 4-bit settle count, the extreme counts 0, 1 and 15 can each be run out edge by edge after a reset from power-down. Random traffic then mixes writes, interrupts and occasional resets. It exercises the less obvious orderings, such as an interrupt that arrives in the cycle when idle is entered, or reset asserted again during the settle window.

// File: rtl/lpm_pkg.sv
// Shared types for the low-power mode controller.
// Assumes a two-bit power-control register with idle at bit 0 and power-down at bit 1.
package lpm_pkg;

    // Bit positions inside the power-control register
    localparam int IDL_BIT = 0;
    localparam int PD_BIT  = 1;

    // Mode status codes seen on the mode output
    localparam logic [1:0] MODE_RUN   = 2'b00;
    localparam logic [1:0] MODE_IDLE  = 2'b01;
    localparam logic [1:0] MODE_PDOWN = 2'b10;

    // Controller states; the settle state reports as run
    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_IDLE  = 2'b01,
        ST_PDOWN = 2'b10,
        ST_STAB  = 2'b11
    } lpm_state_e;

endpackage

// File: rtl/lpm_ctl_reg.sv
// Power-control register holding the idle and power-down request bits.
// It accepts a software write only when the controller says the write is allowed.
// The idle bit is cleared by hardware on an interrupt wake. Reset clears both bits.
module lpm_ctl_reg
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_accept,
    input  logic [1:0] wr_data,
    input  logic       hw_wake,
    output logic [1:0] ctl_bits
);

    logic idl_q;
    logic pd_q;

    // Update the request bits from software writes or hardware wake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idl_q <= 1'b0;
            pd_q  <= 1'b0;
        end else if (wr_accept) begin
            idl_q <= wr_data[IDL_BIT];
            pd_q  <= wr_data[PD_BIT];
        end else if (hw_wake) begin
            idl_q <= 1'b0;
        end
    end

    // Present the bits at their register positions
    always_comb begin
        ctl_bits         = '0;
        ctl_bits[IDL_BIT] = idl_q;
        ctl_bits[PD_BIT]  = pd_q;
    end

endmodule

// File: rtl/lpm_stab_cnt.sv
// Oscillator settle counter. While active, it counts edges and flags done
// on the edge that completes max(limit,1) cycles. It assumes the limit is
// held steady while it counts.
module lpm_stab_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    localparam int CW1 = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CW1-1:0]   cnt_inc;

    // Compare the incremented count with the limit one bit wider, so the top value is safe
    always_comb begin
        cnt_inc = {1'b0, cnt_q} + CW1'(1);
        done    = active && (cnt_inc >= {1'b0, limit});
    end

    // Advance while settling, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (active && !done) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/lpm_mode_fsm.sv
// Mode sequencer: run, idle, power-down and post-reset settle.
// Power-down takes priority over idle. Idle wakes on any interrupt.
// Power-down leaves only through reset. A reset taken in power-down, or
// during the settle phase, goes to settle; otherwise reset goes to run.
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    input  logic       irq_any,
    input  logic       stab_done,
    output lpm_state_e state,
    output logic       wr_accept,
    output logic       hw_wake
);

    lpm_state_e state_q;
    lpm_state_e state_d;

    // Decode write acceptance and wake events from the current state
    always_comb begin
        wr_accept = wr_en && (state_q == ST_RUN);
        hw_wake   = irq_any && (state_q == ST_IDLE);
    end

    // Next-state selection while out of reset
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (wr_accept && wr_data[PD_BIT]) begin
                    state_d = ST_PDOWN;
                end else if (wr_accept && wr_data[IDL_BIT]) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (hw_wake) begin
                    state_d = ST_RUN;
                end
            end
            ST_PDOWN: begin
                state_d = ST_PDOWN;
            end
            ST_STAB: begin
                if (stab_done) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register; reset remembers whether the oscillator was stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (state_q == ST_PDOWN || state_q == ST_STAB) begin
                state_q <= ST_STAB;
            end else begin
                state_q <= ST_RUN;
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/lpm_ctrl.sv
// Top of the low-power mode controller. It ties the control register, the
// mode sequencer and the settle counter together, and it decodes the clock
// gates and the mode status from the state. It assumes that clk is the
// oscillator output and that reset is held long enough to restart it.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_data,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [CNT_W-1:0] stab_cycles,
    output logic [1:0]       ctl_rdata,
    output logic [1:0]       mode,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en
);

    lpm_state_e state;
    logic       wr_accept;
    logic       hw_wake;
    logic       stab_done;
    logic       irq_any;

    // Any enabled interrupt line counts as a wake event
    assign irq_any = |irq_req;

    lpm_ctl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_accept(wr_accept),
        .wr_data  (wr_data),
        .hw_wake  (hw_wake),
        .ctl_bits (ctl_rdata)
    );

    lpm_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .irq_any  (irq_any),
        .stab_done(stab_done),
        .state    (state),
        .wr_accept(wr_accept),
        .hw_wake  (hw_wake)
    );

    lpm_stab_cnt #(.CNT_W(CNT_W)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .active(state == ST_STAB),
        .limit (stab_cycles),
        .done  (stab_done)
    );

    // Clock gates and mode status from the current state; reset forces the oscillator on
    always_comb begin
        cpu_clk_en = (state == ST_RUN);
        per_clk_en = (state == ST_RUN) || (state == ST_IDLE);
        osc_en     = (state != ST_PDOWN) || !rst_n;
        unique case (state)
            ST_IDLE:  mode = MODE_IDLE;
            ST_PDOWN: mode = MODE_PDOWN;
            default:  mode = MODE_RUN;
        endcase
    end

endmodule

// File: rtl/lpm_ctrl_chk.sv
// Property checker for the low-power mode controller, bound to the top module.
// It observes the ports only.
module lpm_ctrl_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_data,
    input logic [N_IRQ-1:0] irq_req,
    input logic [1:0]       ctl_rdata,
    input logic [1:0]       mode,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             osc_en
);

    AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_clk_en && wr_data == 2'b01) |=> (mode == 2'b01)); // R1
    AST_PD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_clk_en && wr_data == 2'b11) |=> (mode == 2'b10 && ctl_rdata == 2'b11)); // R2
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && irq_req != '0) |=> (mode == 2'b00 && !ctl_rdata[0] && cpu_clk_en)); // R3
    AST_PD_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (!osc_en && !cpu_clk_en && !per_clk_en)); // R4
    AST_PD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (mode == 2'b10 && $stable(ctl_rdata))); // R5
    AST_IDLE_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && wr_en && irq_req == '0) |=> (mode == 2'b01 && $stable(ctl_rdata))); // R6
    AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> (!cpu_clk_en && per_clk_en && osc_en)); // R7
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b11)); // R10
    AST_CPU_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (mode == 2'b00 && osc_en && per_clk_en)); // R9

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq_req   (irq_req),
    .ctl_rdata (ctl_rdata),
    .mode      (mode),
    .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en),
    .osc_en    (osc_en)
);

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/100ps
// Self-checking bench: directed corner cases, then seeded random traffic
// compared against a behavioural model built from the requirements.
module lpm_ctrl_tb;

    localparam int N_IRQ = 4;
    localparam int CNT_W = 4;
    localparam int M_RUN = 0, M_IDLE = 1, M_PD = 2, M_STAB = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_data = 2'b00;
    logic [N_IRQ-1:0] irq_req = '0;
    logic [CNT_W-1:0] stab_cycles = 4'd3;
    logic [1:0]       ctl_rdata;
    logic [1:0]       mode;
    logic             cpu_clk_en;
    logic             per_clk_en;
    logic             osc_en;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Behavioural model state
    int   m_state = M_RUN;
    int   m_cnt = 0;
    logic [1:0] m_bits = 2'b00;

    always #2.5 clk = ~clk;

    lpm_ctrl #(.N_IRQ(N_IRQ), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_req(irq_req), .stab_cycles(stab_cycles), .ctl_rdata(ctl_rdata),
        .mode(mode), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en)
    );

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    // Advance one edge and settle just after it
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int exp_mode(input int st);
        if (st == M_IDLE) return 1;
        if (st == M_PD) return 2;
        return 0;
    endfunction

    function automatic int settle_len(input int lim);
        return (lim == 0) ? 1 : lim;
    endfunction

    // Model update at an edge, from the requirements
    task automatic model_edge();
        if (!rst_n) begin
            m_state = (m_state == M_PD || m_state == M_STAB) ? M_STAB : M_RUN;
            m_cnt = 0;
            m_bits = 2'b00;
        end else begin
            case (m_state)
                M_RUN: if (wr_en) begin
                    m_bits = wr_data;
                    if (wr_data[1]) m_state = M_PD;
                    else if (wr_data[0]) m_state = M_IDLE;
                end
                M_IDLE: if (irq_req != '0) begin
                    m_state = M_RUN;
                    m_bits[0] = 1'b0;
                end
                M_STAB: begin
                    m_cnt++;
                    if (m_cnt >= settle_len(int'(stab_cycles))) begin
                        m_state = M_RUN;
                        m_cnt = 0;
                    end
                end
                default: ;
            endcase
        end
    endtask

    task automatic model_compare(input string req);
        chk({req, " mode"}, int'(mode), exp_mode(m_state));
        chk({req, " cpu"}, int'(cpu_clk_en), int'(m_state == M_RUN));
        chk({req, " per"}, int'(per_clk_en), int'(m_state == M_RUN || m_state == M_IDLE));
        chk({req, " osc"}, int'(osc_en), int'(m_state != M_PD || !rst_n));
        chk({req, " rdata"}, int'(ctl_rdata), int'(m_bits));
    endtask

    task automatic write(input logic [1:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
        wr_data = 2'b00;
    endtask

    // Reset from power-down, then count edges until the core clock returns
    task automatic pd_reset_settle(input int lim, input string req);
        int edges;
        stab_cycles = CNT_W'(lim);
        write(2'b11);
        chk({req, " pd entry"}, int'(mode), 2);
        rst_n = 1'b0;
        #1;
        chk({req, " osc during reset"}, int'(osc_en), 1);
        tick();
        tick();
        rst_n = 1'b1;
        #0;
        chk({req, " mode settle"}, int'(mode), 0);
        chk({req, " per gated settle"}, int'(per_clk_en), 0);
        edges = 0;
        while (!cpu_clk_en && edges < 40) begin
            tick();
            edges++;
        end
        chk({req, " settle edges"}, edges, settle_len(lim));
        chk({req, " rdata after"}, int'(ctl_rdata), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        #0;
        // R10: reset state is run
        chk("R10 reset mode", int'(mode), 0);
        chk("R10 reset rdata", int'(ctl_rdata), 0);
        chk("R10 reset cpu", int'(cpu_clk_en), 1);

        // R11: writing zeros stays in run
        write(2'b00);
        chk("R11 mode", int'(mode), 0);
        chk("R11 rdata", int'(ctl_rdata), 0);

        // R1 and R7: idle entry and idle clocks
        write(2'b01);
        chk("R1 mode", int'(mode), 1);
        chk("R1 rdata", int'(ctl_rdata), 1);
        chk("R7 cpu", int'(cpu_clk_en), 0);
        chk("R7 per", int'(per_clk_en), 1);
        chk("R7 osc", int'(osc_en), 1);

        // R6: a write in idle is ignored
        write(2'b10);
        chk("R6 idle write mode", int'(mode), 1);
        chk("R6 idle write rdata", int'(ctl_rdata), 1);

        // R3: a single interrupt line wakes idle
        irq_req = 4'b0100;
        tick();
        irq_req = '0;
        chk("R3 mode", int'(mode), 0);
        chk("R3 rdata", int'(ctl_rdata), 0);
        chk("R3 cpu", int'(cpu_clk_en), 1);

        // R2 and R4: both bits set picks power-down with clocks off
        write(2'b11);
        chk("R2 mode", int'(mode), 2);
        chk("R2 rdata", int'(ctl_rdata), 3);
        chk("R4 osc", int'(osc_en), 0);
        chk("R4 cpu", int'(cpu_clk_en), 0);
        chk("R4 per", int'(per_clk_en), 0);

        // R5 and R6: interrupts and writes do not disturb power-down
        irq_req = '1;
        wr_en = 1'b1;
        wr_data = 2'b00;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R5 mode held", int'(mode), 2);
            chk("R6 rdata frozen", int'(ctl_rdata), 3);
        end
        irq_req = '0;
        wr_en = 1'b0;

        // R9: reset from power-down with several settle counts
        rst_n = 1'b0;
        #1;
        chk("R9 osc in reset", int'(osc_en), 1);
        tick();
        rst_n = 1'b1;
        stab_cycles = 4'd3;
        #0;
        begin
            int edges = 0;
            while (!cpu_clk_en && edges < 40) begin
                tick();
                edges++;
            end
            chk("R9 settle 3", edges, 3);
        end
        pd_reset_settle(0, "R9 lim0");
        pd_reset_settle(1, "R9 lim1");
        pd_reset_settle(15, "R9 lim15");

        // R8: reset in idle returns to run at once
        write(2'b01);
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        #0;
        chk("R8 mode", int'(mode), 0);
        chk("R8 cpu", int'(cpu_clk_en), 1);
        chk("R8 rdata", int'(ctl_rdata), 0);

        // R3: interrupt pending while idle is entered wakes on the next edge
        irq_req = 4'b0001;
        write(2'b01);
        chk("R3 late-irq idle", int'(mode), 1);
        tick();
        chk("R3 late-irq wake", int'(mode), 0);
        irq_req = '0;

        // Random traffic against the model (R1 to R11)
        m_state = M_RUN;
        m_cnt = 0;
        m_bits = 2'b00;
        stab_cycles = 4'd5;
        for (int n = 0; n < 600; n++) begin
            rst_n   = ($urandom_range(0, 39) != 0);
            wr_en   = ($urandom_range(0, 2) == 0);
            wr_data = 2'($urandom_range(0, 3));
            irq_req = ($urandom_range(0, 3) == 0) ? N_IRQ'($urandom_range(1, 15)) : '0;
            tick();
            model_edge();
            model_compare("R1-model");
        end
        rst_n = 1'b1;
        wr_en = 1'b0;
        irq_req = '0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule